// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Acknowledge

This block collects interrupt requests from a row of identical source cells and tells the processor which source to serve. Each cell holds a sticky pending flag, set by a request from its peripheral, and a vector word that can be written at run time. The cells share one interrupt request output. When the processor raises its acknowledge, the acknowledge passes along the row from cell 0 towards cell N-1. The first cell that has an eligible pending request stops it there. That cell then returns its vector on the shared vector bus, and the processor uses the vector to choose a service routine.

Priority comes from position in the row: cell 0 is the highest. An in-service mask records every level that has been entered and not yet finished. A pending source is eligible only when no level at or above its own is in service. A higher-priority source can therefore preempt a running handler. An end-of-interrupt strobe leaves the innermost level and returns to the level that was interrupted.

Top module: `intack_chain`

## Requirements
- R1: A one-cycle high on `src_req[i]` sets the pending flag of cell i on that clock edge. `irq` is high while at least one pending cell is eligible.
- R2: The acknowledge enters cell 0 and passes cell by cell. The lowest-index cell that is pending and eligible claims it. Cells with a higher index never claim it.
- R3: The claim is taken on the first clock edge at which `inta` is sampled high. From the next cycle until `inta` falls, `vec_bus` carries the claiming cell's vector. At all other times `vec_bus` is zero.
- R4: At most one cell holds a claim at any time.
- R5: On the clock edge that samples `inta` low after it was high, the claiming cell's pending flag clears and bit i of `in_service` (bit i = cell i) is set.
- R6: If no cell claims the acknowledge, `vec_bus` reads all-zero and neither the pending flags nor `in_service` change.
- R7: Cell i is eligible only when `in_service[j]` is zero for every j ≤ i. An ineligible pending cell neither drives `irq` nor claims, and it passes the acknowledge on.
- R8: A one-cycle `eoi` clears the lowest-index set bit of `in_service`, if any bit is set.
- R9: When `vec_we` is high, `vec_wdata` is written into the vector register of cell `vec_sel`.
- R10: A request that arrives while `inta` is held high does not change the vector being returned.
- R11: After a synchronous reset, all pending flags, vectors and `in_service` bits are zero, and `irq` and `vec_bus` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Request pulses, one per source cell |
| vec_we | input | 1 | Vector register write strobe |
| vec_sel | input | clog2(N_SRC) | Index of the cell whose vector is written |
| vec_wdata | input | VEC_W | Vector value to write |
| inta | input | 1 | Acknowledge from processor, held high for one vector read |
| eoi | input | 1 | End-of-interrupt strobe |
| irq | output | 1 | Combined interrupt request to processor |
| vec_bus | output | VEC_W | Vector returned by the claiming cell, zero otherwise |
| in_service | output | N_SRC | In-service mask, bit i = cell i |

## Verification
A table of request masks, with one, two, three and all cells asserted at once, is acknowledged. Each row checks that only the nearest requester's vector is returned and only its in-service bit is set. Each row is then drained, which also checks that the remaining requests come out in position order. Directed sequences cover a request at the same level and at a lower level while a handler runs, which must not raise `irq`. They also cover a higher request, which must preempt and then unwind through two end-of-interrupt strobes. A spurious acknowledge must read zero. A request arriving mid-acknowledge must not change the returned vector. A rewritten vector must appear on the next claim.

// File: rtl/intack_pkg.sv
package intack_pkg;

    localparam int DEF_SRC   = 4;
    localparam int DEF_VEC_W = 8;

    // acknowledge edge events seen by every cell
    typedef struct packed {
        logic start;   // first cycle inta sampled high
        logic finish;  // first cycle inta sampled low again
    } ack_evt_t;

endpackage

// File: rtl/intack_ctrl.sv
module intack_ctrl
    import intack_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     inta,
    output ack_evt_t evt
);
    logic inta_q;

    always_ff @(posedge clk) begin
        if (rst) inta_q <= 1'b0;
        else     inta_q <= inta;
    end

    always_comb begin
        evt.start  = inta & ~inta_q;
        evt.finish = ~inta & inta_q;
    end
endmodule

// File: rtl/intack_level.sv
module intack_level #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ack_finish,
    input  logic         eoi,
    input  logic [N-1:0] held,
    output logic [N-1:0] in_service,
    output logic [N-1:0] eligible
);
    logic [N-1:0] mask_q, mask_d, innermost;

    // lowest set bit = highest priority level in service
    assign innermost = mask_q & (~mask_q + 1'b1);

    always_comb begin
        mask_d = mask_q;
        if (eoi)        mask_d = mask_d & ~innermost;
        if (ack_finish) mask_d = mask_d | held;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

    // prefix: eligible only if no level at or above is in service
    assign eligible[0] = ~mask_q[0];
    generate
        for (genvar i = 1; i < N; i++) begin : g_pre
            assign eligible[i] = eligible[i-1] & ~mask_q[i];
        end
    endgenerate

    assign in_service = mask_q;
endmodule

// File: rtl/intack_cell.sv
module intack_cell
    import intack_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          vec_we,
    input  logic [VW-1:0] vec_wdata,
    input  logic          ack_in,
    input  logic          eligible,
    input  ack_evt_t      evt,
    output logic          ack_out,
    output logic          held,
    output logic          pending,
    output logic [VW-1:0] vec_drv
);
    logic          pend_q, held_q;
    logic [VW-1:0] vec_q;
    logic          wants;

    assign wants   = pend_q & eligible;
    assign ack_out = ack_in & ~wants;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            held_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            if (vec_we) vec_q <= vec_wdata;
            if (evt.start)       held_q <= ack_in & wants;
            else if (evt.finish) held_q <= 1'b0;
            // a fresh request at the retire edge keeps the flag set
            if (req)                      pend_q <= 1'b1;
            else if (evt.finish & held_q) pend_q <= 1'b0;
        end
    end

    assign held    = held_q;
    assign pending = pend_q;
    assign vec_drv = held_q ? vec_q : '0;
endmodule

// File: rtl/intack_chain.sv
module intack_chain
    import intack_pkg::*;
#(
    parameter int N_SRC = DEF_SRC,
    parameter int VEC_W = DEF_VEC_W,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_req,
    input  logic             vec_we,
    input  logic [SEL_W-1:0] vec_sel,
    input  logic [VEC_W-1:0] vec_wdata,
    input  logic             inta,
    input  logic             eoi,
    output logic             irq,
    output logic [VEC_W-1:0] vec_bus,
    output logic [N_SRC-1:0] in_service
);
    ack_evt_t         evt;
    logic [N_SRC:0]   ack_link;
    logic [N_SRC-1:0] held, pending, eligible;
    logic [VEC_W-1:0] vec_or [N_SRC+1];
    logic [VEC_W-1:0] vec_cell [N_SRC];

    intack_ctrl u_ctrl (.clk(clk), .rst(rst), .inta(inta), .evt(evt));

    intack_level #(.N(N_SRC)) u_lvl (
        .clk(clk), .rst(rst), .ack_finish(evt.finish), .eoi(eoi),
        .held(held), .in_service(in_service), .eligible(eligible)
    );

    assign ack_link[0] = inta;
    assign vec_or[0]   = '0;

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_cell
            intack_cell #(.VW(VEC_W)) u_cell (
                .clk(clk), .rst(rst), .req(src_req[i]),
                .vec_we(vec_we && (vec_sel == SEL_W'(i))),
                .vec_wdata(vec_wdata),
                .ack_in(ack_link[i]), .eligible(eligible[i]), .evt(evt),
                .ack_out(ack_link[i+1]), .held(held[i]),
                .pending(pending[i]), .vec_drv(vec_cell[i])
            );
            assign vec_or[i+1] = vec_or[i] | vec_cell[i];
        end
    endgenerate

    assign vec_bus = vec_or[N_SRC];
    assign irq     = |(pending & eligible);
endmodule

// File: rtl/intack_chk.sv
module intack_chk #(
    parameter int N = 4,
    parameter int VW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          inta,
    input logic          eoi,
    input logic          ack_start,
    input logic          ack_finish,
    input logic [N-1:0]  held,
    input logic [N-1:0]  in_service,
    input logic [VW-1:0] vec_bus
);
    // R4
    single_claim_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(held));

    // R3
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !inta |=> (vec_bus == '0));

    // R5
    retire_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_finish && held != '0) |=> ((in_service & $past(held)) == $past(held)));

    // R7
    top_level_block_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_start && in_service[0]) |=> (held == '0));

    // R8
    eoi_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi && !ack_finish && in_service != '0) |=>
        ($countones(in_service) + 1 == $countones($past(in_service))));

    // R10
    vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (inta && $past(inta) && $past(inta, 2)) |-> $stable(vec_bus));
endmodule

bind intack_chain intack_chk #(.N(N_SRC), .VW(VEC_W)) u_chk (
    .clk(clk), .rst(rst), .inta(inta), .eoi(eoi),
    .ack_start(evt.start), .ack_finish(evt.finish),
    .held(held), .in_service(in_service), .vec_bus(vec_bus)
);

// File: tb/sim_intack_chain.sv
module sim_intack_chain;
    localparam int N = 4;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src_req = '0;
    logic          vec_we = 1'b0;
    logic [1:0]    vec_sel = '0;
    logic [VW-1:0] vec_wdata = '0;
    logic          inta = 1'b0;
    logic          eoi = 1'b0;
    logic          irq;
    logic [VW-1:0] vec_bus;
    logic [N-1:0]  in_service;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    intack_chain #(.N_SRC(N), .VEC_W(VW)) u0 (.*);

    typedef struct packed {
        logic [N-1:0]  req;
        logic [VW-1:0] vec;
        logic [N-1:0]  isr;
    } row_t;

    // vectors: cell0=40 cell1=51 cell2=62 cell3=73
    localparam row_t ROWS [6] = '{
        '{4'b0001, 8'h40, 4'b0001},
        '{4'b1110, 8'h51, 4'b0010},
        '{4'b1100, 8'h62, 4'b0100},
        '{4'b1000, 8'h73, 4'b1000},
        '{4'b1111, 8'h40, 4'b0001},
        '{4'b1010, 8'h51, 4'b0010}
    };

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse(logic [N-1:0] m);
        src_req = m; tick(); src_req = '0;
    endtask

    task automatic write_vec(int idx, logic [VW-1:0] v);
        vec_we = 1'b1; vec_sel = 2'(idx); vec_wdata = v; tick(); vec_we = 1'b0;
    endtask

    task automatic do_ack(output logic [VW-1:0] v);
        inta = 1'b1; tick(); v = vec_bus; inta = 1'b0; tick();
    endtask

    task automatic do_eoi();
        eoi = 1'b1; tick(); eoi = 1'b0;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
        $finish;
    end

    initial begin
        logic [VW-1:0] v;
        tick(); tick(); rst = 1'b0; tick();
        // R11 reset state
        check("R11 irq", irq, 0);
        check("R11 vec_bus", vec_bus, 0);
        check("R11 in_service", in_service, 0);
        // R11 vector reset to zero: claim cell 0 before programming
        pulse(4'b0001);
        do_ack(v);
        check("R11 vector reset", v, 0);
        do_eoi();

        // R9 program vectors
        for (int i = 0; i < N; i++) write_vec(i, 8'h40 + 8'(i * 17));

        // table: simultaneous requests, nearest wins, then drain in order
        for (int r = 0; r < 6; r++) begin
            pulse(ROWS[r].req);
            check("R1 irq raised", irq, 1);
            do_ack(v);
            check("R2 nearest vector", v, ROWS[r].vec);
            check("R5 in_service", in_service, ROWS[r].isr);
            do_eoi();
            check("R8 eoi clears", in_service, 0);
            for (int k = 0; k < N && irq; k++) begin
                logic [VW-1:0] prev;
                prev = v;
                do_ack(v);
                check("R2 drain order", (v > prev) ? 1 : 0, 1);
                do_eoi();
            end
            check("R5 all drained", irq, 0);
        end

        // R6 spurious acknowledge
        do_ack(v);
        check("R6 spurious vec", v, 0);
        check("R6 spurious isr", in_service, 0);

        // R7 preemption and blocking
        pulse(4'b0100);
        do_ack(v);
        check("R2 cell2 vector", v, 8'h62);
        pulse(4'b1000);
        check("R7 lower blocked irq", irq, 0);
        pulse(4'b0100);
        check("R7 equal blocked irq", irq, 0);
        do_ack(v);
        check("R7 blocked ack spurious", v, 0);
        check("R7 blocked isr unchanged", in_service, 4'b0100);
        pulse(4'b0001);
        check("R7 higher raises irq", irq, 1);
        do_ack(v);
        check("R7 preempt vector", v, 8'h40);
        check("R7 nested isr", in_service, 4'b0101);
        do_eoi();
        check("R8 pop to level 2", in_service, 4'b0100);
        check("R8 still blocked", irq, 0);
        do_eoi();
        check("R8 pop to idle", in_service, 0);
        check("R1 pending kept", irq, 1);
        do_ack(v);
        check("R2 re-request cell2", v, 8'h62);
        do_eoi();
        do_ack(v);
        check("R2 then cell3", v, 8'h73);
        do_eoi();

        // R10 request mid-acknowledge
        pulse(4'b0100);
        inta = 1'b1; tick();
        check("R3 vec during ack", vec_bus, 8'h62);
        src_req = 4'b0001; tick(); src_req = '0;
        check("R10 vec held", vec_bus, 8'h62);
        inta = 1'b0; tick();
        check("R3 vec after ack", vec_bus, 0);
        check("R10 late req pending", irq, 1);
        do_ack(v);
        check("R10 late req served", v, 8'h40);
        do_eoi(); do_eoi();

        // R9 rewrite
        write_vec(1, 8'hC9);
        pulse(4'b0010);
        do_ack(v);
        check("R9 rewritten vector", v, 8'hC9);
        do_eoi();
        check("R8 final idle", in_service, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule